// File: doc/BRIEF.md
# Offload Job Launch Controller

This block sits between a host core and a bank of accelerator units that probe a hash index. The host programs a small set of word registers with the job description: where the input key table starts and how many entries it holds, where the hash table starts, where results are to be written, and which value marks an empty entry. Two further registers say where a block of unit constants lives in memory and how many words it holds. Writing a one to bit 0 of the control register launches the job.

On launch the controller walks the constant block itself. It issues one word read at a time to consecutive word addresses, waits for each response, and broadcasts every returned word to the units together with its index in the block. When the last word has arrived, the units are enabled. The job completes only when every unit reports completion and every result queue is empty. A fault reported during loading or running ends the job as aborted. An aborted job produces nothing the host may treat as valid, so the host redoes the whole operation.

Top module: `offload_ctrl`

## Requirements
- R1: After reset the status reads idle (0), the run enable is low and no load request is issued.
- R2: While the status is idle, done or aborted, writes to the word registers at addresses 0 (table base), 1 (table length), 2 (hash base), 3 (result base), 4 (empty marker), 5 (constant block base) and 6 (constant block length) take effect. Each reads back at its address and drives its job output.
- R3: While the status is loading or running, every register write, including a launch write, is ignored.
- R4: A write of bit 0 = 1 to address 7 with a non-zero constant block length sets the status to loading and issues the first load request, at the constant block base, in the cycle after the write.
- R5: At most one load request is outstanding. Each request is a single-cycle pulse, and the next one follows the response to the previous one, at the next consecutive word address.
- R6: Each accepted response is broadcast once on the constant write port with indices 0, 1, 2, … in order. A response that arrives when no request is outstanding is ignored.
- R7: The run enable stays low during loading and goes high in the cycle after the last response. A launch with a constant block length of zero goes straight to running without any load request.
- R8: From running, the status becomes done in the cycle after every unit-done bit is high and every queue-empty bit is high, and not before.
- R9: A fault while loading or running sets the status to aborted in the next cycle, drops the run enable and keeps done low. Aborted holds until the next launch.
- R10: A launch from the done or aborted status starts a new job.
- R11: The status register at address 8 encodes idle=0, loading=1, running=2, done=3, aborted=4. op_done is high exactly in done and op_abort is high exactly in aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register word address for writes and reads |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for cfg_addr_i (combinational) |
| ld_req_valid_o | output | 1 | Constant block load request pulse |
| ld_req_addr_o | output | 32 | Word address of the load request |
| ld_rsp_valid_i | input | 1 | Load response valid |
| ld_rsp_data_i | input | 32 | Load response data |
| cb_we_o | output | 1 | Constant word broadcast strobe |
| cb_idx_o | output | 16 | Index of the broadcast word in the block |
| cb_data_o | output | 32 | Broadcast constant word |
| job_tbl_base_o | output | 32 | Input table base |
| job_tbl_len_o | output | 16 | Input table length |
| job_hash_base_o | output | 32 | Hash table base |
| job_res_base_o | output | 32 | Results region start |
| job_null_id_o | output | 32 | Empty entry marker |
| run_en_o | output | 1 | Unit execution enable |
| unit_done_i | input | 4 | Per-unit completion flags |
| queue_empty_i | input | 4 | Per-queue empty flags |
| fault_i | input | 1 | Fatal fault from the units |
| op_done_o | output | 1 | Job completed |
| op_abort_o | output | 1 | Job aborted |

## Verification
The bench injects responses with different latencies and checks that no second request goes out before a response, because a loader that pipelined requests would overrun a memory that serves one read at a time. It checks that a stray response after an abort or in the done state changes nothing, because a loader that did not track its outstanding request would broadcast garbage constants. It checks done with one unit still busy and with one queue still holding data; a design that watched only the unit flags would report done early and lose results. It also checks writes during loading and running, a launch with an empty constant block, and faults in both the loading and running phases. A design that got any of these wrong would corrupt the job, hang in loading, or report a partial result as complete.

// File: rtl/offload_pkg.sv
package offload_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_RUN   = 3'd2,
        ST_DONE  = 3'd3,
        ST_ABORT = 3'd4
    } op_status_e;

    typedef enum logic [1:0] {
        LP_IDLE  = 2'd0,
        LP_ISSUE = 2'd1,
        LP_WAIT  = 2'd2
    } ld_phase_e;

    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] RA_TBL_BASE  = 4'd0;
    localparam logic [REG_AW-1:0] RA_TBL_LEN   = 4'd1;
    localparam logic [REG_AW-1:0] RA_HASH_BASE = 4'd2;
    localparam logic [REG_AW-1:0] RA_RES_BASE  = 4'd3;
    localparam logic [REG_AW-1:0] RA_NULL_ID   = 4'd4;
    localparam logic [REG_AW-1:0] RA_CB_BASE   = 4'd5;
    localparam logic [REG_AW-1:0] RA_CB_LEN    = 4'd6;
    localparam logic [REG_AW-1:0] RA_CTRL      = 4'd7;
    localparam logic [REG_AW-1:0] RA_STATUS    = 4'd8;

endpackage

// File: rtl/offload_regfile.sv
module offload_regfile
    import offload_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              lock_i,
    input  logic [2:0]        status_i,
    output logic              start_o,
    output logic [ADDR_W-1:0] tbl_base_o,
    output logic [LEN_W-1:0]  tbl_len_o,
    output logic [ADDR_W-1:0] hash_base_o,
    output logic [ADDR_W-1:0] res_base_o,
    output logic [DATA_W-1:0] null_id_o,
    output logic [ADDR_W-1:0] cb_base_o,
    output logic [LEN_W-1:0]  cb_len_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] tbl_base;
        logic [LEN_W-1:0]  tbl_len;
        logic [ADDR_W-1:0] hash_base;
        logic [ADDR_W-1:0] res_base;
        logic [DATA_W-1:0] null_id;
        logic [ADDR_W-1:0] cb_base;
        logic [LEN_W-1:0]  cb_len;
    } job_regs_t;

    job_regs_t r_d, r_q;
    logic      start_d;

    always_comb begin
        r_d     = r_q;
        start_d = 1'b0;
        if (we_i && !lock_i) begin
            case (addr_i)
                RA_TBL_BASE:  r_d.tbl_base  = wdata_i[ADDR_W-1:0];
                RA_TBL_LEN:   r_d.tbl_len   = wdata_i[LEN_W-1:0];
                RA_HASH_BASE: r_d.hash_base = wdata_i[ADDR_W-1:0];
                RA_RES_BASE:  r_d.res_base  = wdata_i[ADDR_W-1:0];
                RA_NULL_ID:   r_d.null_id   = wdata_i;
                RA_CB_BASE:   r_d.cb_base   = wdata_i[ADDR_W-1:0];
                RA_CB_LEN:    r_d.cb_len    = wdata_i[LEN_W-1:0];
                RA_CTRL:      start_d       = wdata_i[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    always_comb begin
        case (addr_i)
            RA_TBL_BASE:  rdata_o = DATA_W'(r_q.tbl_base);
            RA_TBL_LEN:   rdata_o = DATA_W'(r_q.tbl_len);
            RA_HASH_BASE: rdata_o = DATA_W'(r_q.hash_base);
            RA_RES_BASE:  rdata_o = DATA_W'(r_q.res_base);
            RA_NULL_ID:   rdata_o = r_q.null_id;
            RA_CB_BASE:   rdata_o = DATA_W'(r_q.cb_base);
            RA_CB_LEN:    rdata_o = DATA_W'(r_q.cb_len);
            RA_STATUS:    rdata_o = DATA_W'(status_i);
            default:      rdata_o = '0;
        endcase
    end

    assign start_o     = start_d;
    assign tbl_base_o  = r_q.tbl_base;
    assign tbl_len_o   = r_q.tbl_len;
    assign hash_base_o = r_q.hash_base;
    assign res_base_o  = r_q.res_base;
    assign null_id_o   = r_q.null_id;
    assign cb_base_o   = r_q.cb_base;
    assign cb_len_o    = r_q.cb_len;

    // R3: a locked cycle leaves every job register unchanged at the next edge
    assert_regs_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(lock_i) |-> $stable(r_q));

endmodule

// File: rtl/offload_loader.sv
module offload_loader
    import offload_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              req_valid_o,
    output logic [ADDR_W-1:0] req_addr_o,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    output logic              cw_we_o,
    output logic [LEN_W-1:0]  cw_idx_o,
    output logic [DATA_W-1:0] cw_data_o,
    output logic              finish_o
);

    typedef struct packed {
        ld_phase_e         phase;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  idx;
    } ld_state_t;

    ld_state_t s_d, s_q;
    logic      last_word;
    logic      accept;

    assign last_word = (s_q.idx == len_i - LEN_W'(1));
    assign accept    = (s_q.phase == LP_WAIT) && rsp_valid_i;

    always_comb begin
        s_d = s_q;
        if (abort_i) begin
            s_d.phase = LP_IDLE;
        end else begin
            case (s_q.phase)
                LP_IDLE: begin
                    if (start_i && (len_i != '0)) begin
                        s_d.phase = LP_ISSUE;
                        s_d.addr  = base_i;
                        s_d.idx   = '0;
                    end
                end
                LP_ISSUE: s_d.phase = LP_WAIT;
                LP_WAIT: begin
                    if (rsp_valid_i) begin
                        if (last_word) begin
                            s_d.phase = LP_IDLE;
                        end else begin
                            s_d.phase = LP_ISSUE;
                            s_d.addr  = s_q.addr + ADDR_W'(1);
                            s_d.idx   = s_q.idx + LEN_W'(1);
                        end
                    end
                end
                default: s_d.phase = LP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{phase: LP_IDLE, addr: '0, idx: '0};
        else         s_q <= s_d;
    end

    assign req_valid_o = (s_q.phase == LP_ISSUE);
    assign req_addr_o  = s_q.addr;
    assign cw_we_o     = accept;
    assign cw_idx_o    = s_q.idx;
    assign cw_data_o   = rsp_data_i;
    assign finish_o    = accept && last_word;

    // R5: a request lasts one cycle and is never directly followed by another
    assert_single_outstanding_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_o |=> !req_valid_o);

    // R5: after a non-final response the next request goes to the following word
    assert_next_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cw_we_o && !finish_o && !abort_i) |=>
            (req_valid_o && (req_addr_o == $past(req_addr_o) + ADDR_W'(1))));

    // R6: broadcast indices stay inside the block
    assert_idx_in_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cw_we_o |-> (cw_idx_o < len_i));

endmodule

// File: rtl/offload_seq.sv
module offload_seq
    import offload_pkg::*;
#(
    parameter int NUM_UNITS  = 4,
    parameter int NUM_QUEUES = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  start_i,
    input  logic                  len_zero_i,
    input  logic                  load_done_i,
    input  logic                  fault_i,
    input  logic [NUM_UNITS-1:0]  units_done_i,
    input  logic [NUM_QUEUES-1:0] queues_empty_i,
    output op_status_e            status_o,
    output logic                  lock_o,
    output logic                  run_en_o,
    output logic                  op_done_o,
    output logic                  op_abort_o
);

    typedef struct packed {
        op_status_e status;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic       all_idle;

    assign all_idle = (&units_done_i) && (&queues_empty_i);

    always_comb begin
        s_d = s_q;
        case (s_q.status)
            ST_IDLE, ST_DONE, ST_ABORT: begin
                if (start_i) s_d.status = len_zero_i ? ST_RUN : ST_LOAD;
            end
            ST_LOAD: begin
                if (fault_i)          s_d.status = ST_ABORT;
                else if (load_done_i) s_d.status = ST_RUN;
            end
            ST_RUN: begin
                if (fault_i)       s_d.status = ST_ABORT;
                else if (all_idle) s_d.status = ST_DONE;
            end
            default: s_d.status = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{status: ST_IDLE};
        else         s_q <= s_d;
    end

    assign status_o   = s_q.status;
    assign lock_o     = (s_q.status == ST_LOAD) || (s_q.status == ST_RUN);
    assign run_en_o   = (s_q.status == ST_RUN);
    assign op_done_o  = (s_q.status == ST_DONE);
    assign op_abort_o = (s_q.status == ST_ABORT);

    // R8: entering done requires every unit finished and every queue drained
    assert_done_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((s_q.status == ST_DONE) && ($past(s_q.status) == ST_RUN)) |->
            $past(all_idle));

    // R9: a fault in an active phase aborts on the next edge
    assert_fault_aborts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fault_i && lock_o) |=> (s_q.status == ST_ABORT));

    // R9: aborted persists until a launch
    assert_abort_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((s_q.status == ST_ABORT) && !start_i) |=> (s_q.status == ST_ABORT));

endmodule

// File: rtl/offload_ctrl.sv
module offload_ctrl
    import offload_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LEN_W      = 16,
    parameter int NUM_UNITS  = 4,
    parameter int NUM_QUEUES = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  cfg_we_i,
    input  logic [REG_AW-1:0]     cfg_addr_i,
    input  logic [DATA_W-1:0]     cfg_wdata_i,
    output logic [DATA_W-1:0]     cfg_rdata_o,
    output logic                  ld_req_valid_o,
    output logic [ADDR_W-1:0]     ld_req_addr_o,
    input  logic                  ld_rsp_valid_i,
    input  logic [DATA_W-1:0]     ld_rsp_data_i,
    output logic                  cb_we_o,
    output logic [LEN_W-1:0]      cb_idx_o,
    output logic [DATA_W-1:0]     cb_data_o,
    output logic [ADDR_W-1:0]     job_tbl_base_o,
    output logic [LEN_W-1:0]      job_tbl_len_o,
    output logic [ADDR_W-1:0]     job_hash_base_o,
    output logic [ADDR_W-1:0]     job_res_base_o,
    output logic [DATA_W-1:0]     job_null_id_o,
    output logic                  run_en_o,
    input  logic [NUM_UNITS-1:0]  unit_done_i,
    input  logic [NUM_QUEUES-1:0] queue_empty_i,
    input  logic                  fault_i,
    output logic                  op_done_o,
    output logic                  op_abort_o
);

    op_status_e        status;
    logic              lock;
    logic              start;
    logic              load_done;
    logic [ADDR_W-1:0] cb_base;
    logic [LEN_W-1:0]  cb_len;
    logic              abort_load;

    assign abort_load = fault_i && lock;

    offload_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .we_i        (cfg_we_i),
        .addr_i      (cfg_addr_i),
        .wdata_i     (cfg_wdata_i),
        .rdata_o     (cfg_rdata_o),
        .lock_i      (lock),
        .status_i    (3'(status)),
        .start_o     (start),
        .tbl_base_o  (job_tbl_base_o),
        .tbl_len_o   (job_tbl_len_o),
        .hash_base_o (job_hash_base_o),
        .res_base_o  (job_res_base_o),
        .null_id_o   (job_null_id_o),
        .cb_base_o   (cb_base),
        .cb_len_o    (cb_len)
    );

    offload_loader #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_loader (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start),
        .abort_i     (abort_load),
        .base_i      (cb_base),
        .len_i       (cb_len),
        .req_valid_o (ld_req_valid_o),
        .req_addr_o  (ld_req_addr_o),
        .rsp_valid_i (ld_rsp_valid_i),
        .rsp_data_i  (ld_rsp_data_i),
        .cw_we_o     (cb_we_o),
        .cw_idx_o    (cb_idx_o),
        .cw_data_o   (cb_data_o),
        .finish_o    (load_done)
    );

    offload_seq #(
        .NUM_UNITS  (NUM_UNITS),
        .NUM_QUEUES (NUM_QUEUES)
    ) u_seq (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .start_i        (start),
        .len_zero_i     (cb_len == '0),
        .load_done_i    (load_done),
        .fault_i        (fault_i),
        .units_done_i   (unit_done_i),
        .queues_empty_i (queue_empty_i),
        .status_o       (status),
        .lock_o         (lock),
        .run_en_o       (run_en_o),
        .op_done_o      (op_done_o),
        .op_abort_o     (op_abort_o)
    );

    // R7: the units are enabled only after the loader's last word or an empty-block launch
    assert_run_after_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(run_en_o) |-> $past(load_done || (start && (cb_len == '0))));

    // R6: no constant is broadcast unless a load was requested earlier in the job
    assert_bcast_only_loading_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cb_we_o |-> (status == ST_LOAD));

endmodule

// File: tb/sim_offload_ctrl.sv
module sim_offload_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        ld_req_valid;
    logic [31:0] ld_req_addr;
    logic        ld_rsp_valid = 1'b0;
    logic [31:0] ld_rsp_data = '0;
    logic        cb_we;
    logic [15:0] cb_idx;
    logic [31:0] cb_data;
    logic [31:0] job_tbl_base, job_hash_base, job_res_base, job_null_id;
    logic [15:0] job_tbl_len;
    logic        run_en;
    logic [3:0]  unit_done = '0;
    logic [3:0]  queue_empty = '1;
    logic        fault = 1'b0;
    logic        op_done, op_abort;

    always #4 clk = ~clk;

    offload_ctrl u0 (
        .clk_i (clk), .rst_ni (rst_n),
        .cfg_we_i (cfg_we), .cfg_addr_i (cfg_addr), .cfg_wdata_i (cfg_wdata),
        .cfg_rdata_o (cfg_rdata),
        .ld_req_valid_o (ld_req_valid), .ld_req_addr_o (ld_req_addr),
        .ld_rsp_valid_i (ld_rsp_valid), .ld_rsp_data_i (ld_rsp_data),
        .cb_we_o (cb_we), .cb_idx_o (cb_idx), .cb_data_o (cb_data),
        .job_tbl_base_o (job_tbl_base), .job_tbl_len_o (job_tbl_len),
        .job_hash_base_o (job_hash_base), .job_res_base_o (job_res_base),
        .job_null_id_o (job_null_id), .run_en_o (run_en),
        .unit_done_i (unit_done), .queue_empty_i (queue_empty),
        .fault_i (fault), .op_done_o (op_done), .op_abort_o (op_abort)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // memory responder and logs
    int          lat = 0;
    bit          spur = 1'b0;
    int          req_n = 0;
    int          overlap = 0;
    logic [31:0] req_log [0:15];
    int          cw_n = 0;
    logic [15:0] cw_idx_log [0:15];
    logic [31:0] cw_dat_log [0:15];

    function automatic logic [31:0] pat(input logic [31:0] a);
        return 32'hC0DE_0000 ^ (a * 32'd7);
    endfunction

    initial begin : responder
        bit          pend = 1'b0;
        int          cnt = 0;
        logic [31:0] paddr = '0;
        forever begin
            @(negedge clk);
            ld_rsp_valid = 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    ld_rsp_valid = 1'b1;
                    ld_rsp_data  = pat(paddr);
                    pend = 1'b0;
                end else cnt--;
            end else if (spur) begin
                ld_rsp_valid = 1'b1;
                ld_rsp_data  = 32'hDEAD_BEEF;
                spur = 1'b0;
            end
            if (ld_req_valid === 1'b1) begin
                if (pend) overlap++;
                pend = 1'b1;
                cnt = lat;
                paddr = ld_req_addr;
                if (req_n < 16) req_log[req_n] = ld_req_addr;
                req_n++;
            end
        end
    end

    initial begin : bcast_monitor
        forever begin
            @(posedge clk);
            if (cb_we === 1'b1) begin
                if (cw_n < 16) begin
                    cw_idx_log[cw_n] = cb_idx;
                    cw_dat_log[cw_n] = cb_data;
                end
                cw_n++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        cfg_addr = a;
        #1;
        v = cfg_rdata;
    endtask

    task automatic wait_run();
        for (int i = 0; i < 300; i++) begin
            if (run_en === 1'b1) break;
            @(negedge clk);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'd8, v);
        chk("R1 status idle", v, 32'd0);
        chk("R1 run_en low", 32'(run_en), 32'd0);
        chk("R1 no request", 32'(ld_req_valid), 32'd0);
        chk("R11 op_done low", 32'(op_done), 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(4'd0, 32'h1000_0040);
        wr(4'd1, 32'h0000_0123);
        wr(4'd2, 32'h2000_0000);
        wr(4'd3, 32'h3000_0800);
        wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd0, v); chk("R2 table base", v, 32'h1000_0040);
        rd(4'd1, v); chk("R2 table length", v, 32'h0000_0123);
        rd(4'd2, v); chk("R2 hash base", v, 32'h2000_0000);
        rd(4'd3, v); chk("R2 result base", v, 32'h3000_0800);
        rd(4'd4, v); chk("R2 empty marker", v, 32'hFFFF_FFFF);
        chk("R2 job table base out", job_tbl_base, 32'h1000_0040);
        chk("R2 job length out", 32'(job_tbl_len), 32'h123);
        chk("R2 job hash out", job_hash_base, 32'h2000_0000);
        chk("R2 job result out", job_res_base, 32'h3000_0800);
        chk("R2 job marker out", job_null_id, 32'hFFFF_FFFF);
    endtask

    task automatic t_load();
        logic [31:0] v;
        lat = 2; req_n = 0; cw_n = 0; overlap = 0;
        wr(4'd5, 32'h0000_0100);
        wr(4'd6, 32'd5);
        rd(4'd5, v); chk("R2 block base", v, 32'h100);
        rd(4'd6, v); chk("R2 block length", v, 32'd5);
        wr(4'd7, 32'd1);
        chk("R4 first request", 32'(ld_req_valid), 32'd1);
        chk("R4 first address", ld_req_addr, 32'h100);
        rd(4'd8, v); chk("R4 status loading", v, 32'd1);
        chk("R7 run_en low while loading", 32'(run_en), 32'd0);
        wait_run();
        rd(4'd8, v); chk("R7 status running", v, 32'd2);
        chk("R5 request count", 32'(req_n), 32'd5);
        chk("R5 no overlap", 32'(overlap), 32'd0);
        for (int i = 0; i < 5; i++) begin
            chk("R5 consecutive address", req_log[i], 32'h100 + 32'(i));
            chk("R6 broadcast index", 32'(cw_idx_log[i]), 32'(i));
            chk("R6 broadcast data", cw_dat_log[i], pat(32'h100 + 32'(i)));
        end
        chk("R6 broadcast count", 32'(cw_n), 32'd5);
    endtask

    task automatic t_lock_run();
        logic [31:0] v;
        int rq;
        rq = req_n;
        wr(4'd0, 32'hBAD0_0000);
        wr(4'd6, 32'd9);
        wr(4'd7, 32'd1);
        rd(4'd0, v); chk("R3 base unchanged in run", v, 32'h1000_0040);
        rd(4'd6, v); chk("R3 block length unchanged", v, 32'd5);
        rd(4'd8, v); chk("R3 launch ignored in run", v, 32'd2);
        idle_cycles(3);
        chk("R3 no request from ignored launch", 32'(req_n), 32'(rq));
    endtask

    task automatic t_done();
        logic [31:0] v;
        @(negedge clk);
        unit_done = 4'b0111; queue_empty = 4'b1111;
        idle_cycles(3);
        rd(4'd8, v); chk("R8 busy unit holds running", v, 32'd2);
        unit_done = 4'b1111; queue_empty = 4'b1101;
        idle_cycles(3);
        rd(4'd8, v); chk("R8 non-empty queue holds running", v, 32'd2);
        chk("R8 op_done low", 32'(op_done), 32'd0);
        queue_empty = 4'b1111;
        @(negedge clk);
        rd(4'd8, v); chk("R8 status done", v, 32'd3);
        chk("R11 op_done high", 32'(op_done), 32'd1);
        chk("R8 run_en low in done", 32'(run_en), 32'd0);
    endtask

    task automatic t_spurious();
        int c;
        c = cw_n;
        spur = 1'b1;
        idle_cycles(3);
        chk("R6 stray response ignored", 32'(cw_n), 32'(c));
    endtask

    task automatic t_abort_load();
        logic [31:0] v;
        int c;
        unit_done = '0;
        lat = 3; cw_n = 0; req_n = 0;
        wr(4'd6, 32'd4);
        wr(4'd7, 32'd1);
        rd(4'd8, v); chk("R10 launch from done", v, 32'd1);
        wr(4'd0, 32'h7777_0000);
        rd(4'd0, v); chk("R3 write ignored while loading", v, 32'h1000_0040);
        fault = 1'b1;
        @(negedge clk);
        fault = 1'b0;
        rd(4'd8, v); chk("R9 aborted from loading", v, 32'd4);
        chk("R11 op_abort high", 32'(op_abort), 32'd1);
        chk("R9 run_en low", 32'(run_en), 32'd0);
        c = cw_n;
        idle_cycles(8);
        chk("R6 late response after abort ignored", 32'(cw_n), 32'(c));
        unit_done = '1;
        idle_cycles(2);
        rd(4'd8, v); chk("R9 abort holds", v, 32'd4);
        chk("R9 op_done stays low", 32'(op_done), 32'd0);
        unit_done = '0;
    endtask

    task automatic t_abort_run();
        logic [31:0] v;
        lat = 0; cw_n = 0;
        wr(4'd6, 32'd2);
        rd(4'd6, v); chk("R2 write accepted in aborted", v, 32'd2);
        wr(4'd7, 32'd1);
        wait_run();
        rd(4'd8, v); chk("R10 relaunch from aborted", v, 32'd2);
        chk("R6 two words broadcast", 32'(cw_n), 32'd2);
        @(negedge clk);
        fault = 1'b1;
        @(negedge clk);
        fault = 1'b0;
        rd(4'd8, v); chk("R9 aborted from running", v, 32'd4);
        chk("R9 run_en dropped", 32'(run_en), 32'd0);
    endtask

    task automatic t_zero_len();
        logic [31:0] v;
        int rq;
        rq = req_n;
        wr(4'd6, 32'd0);
        wr(4'd7, 32'd1);
        rd(4'd8, v); chk("R7 empty block runs at once", v, 32'd2);
        chk("R7 run_en high", 32'(run_en), 32'd1);
        idle_cycles(3);
        chk("R7 no request for empty block", 32'(req_n), 32'(rq));
    endtask

    initial begin : watchdog
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_load();
        t_lock_run();
        t_done();
        t_spurious();
        t_abort_load();
        t_abort_run();
        t_zero_len();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule